// File: doc/BRIEF.md
# Reuse and Stack Distance Profiler

This block observes a stream of memory accesses. Each access carries a cache-line address and the identifier of the instruction that issued it. The block keeps a small fully associative stack of recently touched lines, ordered from most to least recently used. For every access it reports two distances back to the previous touch of the same line. The stack distance is the number of distinct other lines touched in between. The reuse distance is the number of accesses in between, repeats included. The stack distance is credited in two directions. It is the backward distance of the current access, and it is also the forward distance of the earlier access, whose instruction identifier is reported alongside.

Every reported stack distance also lands in a histogram with one bin per distance plus a bin for "not in the stack". A read port takes a cache size C in lines and returns how many recorded accesses would have missed in a fully associative LRU cache of that size. An access misses when its stack distance is C or more. Dividing this count by the total count (the result for C = 0) gives the miss ratio for that size. The stack depth bounds the largest size that can be told apart from "infinite".

`rst_n` is asynchronous and active low. Its release is expected to be already synchronous to `clk`.

Top module: `rsd_profiler`

## Requirements
- R1: While reset is asserted and directly after it, `res_valid` and `qry_done` are 0, the stack holds no lines and every histogram bin is zero, so a query for C = 0 returns 0.
- R2: `res_valid` is 1 in exactly the cycle after a cycle with `acc_valid` = 1. All result fields are registered and belong to that access.
- R3: When the line is in the stack, `res_stack` equals the number of distinct other lines accessed since its previous access, and `res_inf` is 0. An immediate repeat of a line gives 0.
- R4: A line not in the stack (a first touch, or one pushed out) gives `res_inf` = 1, `res_stack` = DEPTH, `res_reuse` all ones and `res_prev_id` = 0.
- R5: When the line is found, `res_reuse` equals the number of accesses strictly between the previous access to that line and this one, modulo 2^IDX_W.
- R6: `res_cur_id` is the identifier of the current access. When the line is found, `res_prev_id` is the identifier of the previous access to that line, which is the access the forward distance belongs to.
- R7: The stack holds the DEPTH most recently used distinct lines. With DEPTH-1 distinct lines in between, the line is still found at distance DEPTH-1. With DEPTH distinct lines in between, it is reported as infinite.
- R8: Every access adds one to the bin for its stack distance, with bin DEPTH used for infinite. A query with size C returns the sum of all bins with index >= C.
- R9: `qry_done` is 1 in exactly the cycle after `qry_valid`. The count covers the accesses taken on earlier clock edges only. An access in the same cycle as the query is not included.
- R10: A query size above DEPTH is treated as DEPTH and returns the infinite bin alone.
- R11: Each histogram bin saturates at 2^CNT_W-1 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_line | input | ADDR_W | Cache-line address of the access |
| acc_id | input | ID_W | Instruction identifier of the access |
| qry_valid | input | 1 | Start a miss-count query |
| qry_size | input | $clog2(DEPTH+1) | Cache size C in lines |
| res_valid | output | 1 | Result fields are valid |
| res_reuse | output | IDX_W | Reuse distance, all ones if infinite |
| res_stack | output | $clog2(DEPTH+1) | Stack distance, DEPTH if infinite |
| res_inf | output | 1 | Line was not in the stack |
| res_cur_id | output | ID_W | Identifier of the current access |
| res_prev_id | output | ID_W | Identifier of the earlier access to the line |
| qry_done | output | 1 | Query result valid |
| qry_misses | output | CNT_W+$clog2(DEPTH+1) | Number of recorded distances >= C |

## Verification
Two things can happen on the same edge: the recording of an access into the histogram and the sampling of a query. In the mixed-traffic phase the bench raises `qry_valid` together with `acc_valid` on many cycles, with varying sizes. The reference model forms the expected count from its histogram before that cycle's access is applied. So any design that lets the same-cycle access into the count, or that drops it from later queries, shows a mismatch. Queries on the next cycles confirm that the access was still recorded.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
  // Upper bound on the supported stack depth. It keeps the match and
  // query logic within a sensible depth.
  localparam int unsigned RSD_MAX_DEPTH = 64;

  // Result of looking up a line in the stack.
  typedef enum logic {
    LOOK_FOUND = 1'b0,
    LOOK_ABSENT = 1'b1
  } look_e;
endpackage

// File: rtl/rsd_lru_stack.sv
module rsd_lru_stack #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned ID_W   = 6,
  parameter int unsigned IDX_W  = 12,
  localparam int unsigned POS_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] upd_line,
  input  logic [ID_W-1:0]   upd_id,
  input  logic [IDX_W-1:0]  upd_idx,
  output rsd_pkg::look_e    look_kind,
  output logic [POS_W-1:0]  look_pos,
  output logic [ID_W-1:0]   look_id,
  output logic [IDX_W-1:0]  look_idx
);
  localparam logic [POS_W-1:0] ABSENT_POS = POS_W'(DEPTH);

  // Entry 0 is the most recently used line.
  logic              vld_v  [DEPTH];
  logic [ADDR_W-1:0] line_v [DEPTH];
  logic [ID_W-1:0]   id_v   [DEPTH];
  logic [IDX_W-1:0]  idx_v  [DEPTH];

  logic [POS_W-1:0]  hit_pos;
  logic [ID_W-1:0]   hit_id;
  logic [IDX_W-1:0]  hit_idx;

  // Associative match. Lines are unique in the stack, so the search order
  // only matters for robustness.
  always_comb begin
    hit_pos = ABSENT_POS;
    hit_id  = '0;
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vld_v[i] && (line_v[i] == upd_line)) begin
        hit_pos = POS_W'(i);
        hit_id  = id_v[i];
        hit_idx = idx_v[i];
      end
    end
  end

  assign look_pos  = hit_pos;
  assign look_id   = hit_id;
  assign look_idx  = hit_idx;
  assign look_kind = (hit_pos == ABSENT_POS) ? rsd_pkg::LOOK_ABSENT
                                             : rsd_pkg::LOOK_FOUND;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic              v_q, v_d;
    logic [ADDR_W-1:0] l_q, l_d;
    logic [ID_W-1:0]   i_q, i_d;
    logic [IDX_W-1:0]  x_q, x_d;

    if (g == 0) begin : g_mru
      // The touched line always lands at the top.
      always_comb begin
        v_d = 1'b1;
        l_d = upd_line;
        i_d = upd_id;
        x_d = upd_idx;
      end
    end else begin : g_lower
      localparam logic [POS_W-1:0] GPOS = POS_W'(g);
      // Entries at or above the hit position move down by one. On a miss
      // all of them move, and the bottom entry drops out.
      always_comb begin
        if (GPOS <= hit_pos) begin
          v_d = vld_v[g-1];
          l_d = line_v[g-1];
          i_d = id_v[g-1];
          x_d = idx_v[g-1];
        end else begin
          v_d = v_q;
          l_d = l_q;
          i_d = i_q;
          x_d = x_q;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        l_q <= '0;
        i_q <= '0;
        x_q <= '0;
      end else if (upd_en) begin
        v_q <= v_d;
        l_q <= l_d;
        i_q <= i_d;
        x_q <= x_d;
      end
    end

    assign vld_v[g]  = v_q;
    assign line_v[g] = l_q;
    assign id_v[g]   = i_q;
    assign idx_v[g]  = x_q;
  end

  initial begin
    if (DEPTH < 2 || DEPTH > rsd_pkg::RSD_MAX_DEPTH)
      $error("rsd_lru_stack: DEPTH out of range");
  end
endmodule

// File: rtl/rsd_hist.sv
module rsd_hist #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 10,
  localparam int unsigned POS_W = $clog2(DEPTH + 1),
  localparam int unsigned SUM_W = CNT_W + POS_W,
  localparam int unsigned NBINS = DEPTH + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic [POS_W-1:0] inc_bin,
  input  logic             qry_en,
  input  logic [POS_W-1:0] qry_size,
  output logic             qry_done,
  output logic [SUM_W-1:0] qry_sum
);
  localparam logic [POS_W-1:0] TOP_BIN = POS_W'(DEPTH);

  logic [CNT_W-1:0] bin_v [NBINS];

  for (genvar b = 0; b < NBINS; b++) begin : g_bin
    localparam logic [POS_W-1:0] BIDX = POS_W'(b);
    logic [CNT_W-1:0] c_q, c_d;

    // Saturating increment.
    always_comb begin
      c_d = c_q;
      if (inc_en && (inc_bin == BIDX) && (c_q != {CNT_W{1'b1}}))
        c_d = c_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) c_q <= '0;
      else if (inc_en) c_q <= c_d;
    end

    assign bin_v[b] = c_q;
  end

  logic [POS_W-1:0] size_eff;
  logic [SUM_W-1:0] sum_c;
  logic             done_q;
  logic [SUM_W-1:0] sum_q;

  assign size_eff = (qry_size > TOP_BIN) ? TOP_BIN : qry_size;

  // Sum every bin whose distance would miss in a cache of size_eff lines.
  always_comb begin
    sum_c = '0;
    for (int b = 0; b < NBINS; b++) begin
      if (POS_W'(b) >= size_eff) sum_c = sum_c + SUM_W'(bin_v[b]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      sum_q  <= '0;
    end else begin
      done_q <= qry_en;
      if (qry_en) sum_q <= sum_c;
    end
  end

  assign qry_done = done_q;
  assign qry_sum  = sum_q;
endmodule

// File: rtl/rsd_profiler.sv
module rsd_profiler #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned ID_W   = 6,
  parameter int unsigned IDX_W  = 12,
  parameter int unsigned CNT_W  = 10
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 acc_valid,
  input  logic [ADDR_W-1:0]                    acc_line,
  input  logic [ID_W-1:0]                      acc_id,
  input  logic                                 qry_valid,
  input  logic [$clog2(DEPTH+1)-1:0]           qry_size,
  output logic                                 res_valid,
  output logic [IDX_W-1:0]                     res_reuse,
  output logic [$clog2(DEPTH+1)-1:0]           res_stack,
  output logic                                 res_inf,
  output logic [ID_W-1:0]                      res_cur_id,
  output logic [ID_W-1:0]                      res_prev_id,
  output logic                                 qry_done,
  output logic [CNT_W+$clog2(DEPTH+1)-1:0]     qry_misses
);
  localparam int unsigned POS_W = $clog2(DEPTH + 1);
  localparam int unsigned SUM_W = CNT_W + POS_W;

  rsd_pkg::look_e   look_kind;
  logic [POS_W-1:0] look_pos;
  logic [ID_W-1:0]  look_id;
  logic [IDX_W-1:0] look_idx;

  // Running access index, used to form reuse distances.
  logic [IDX_W-1:0] idx_q, idx_d;

  rsd_lru_stack #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W),
    .ID_W  (ID_W),
    .IDX_W (IDX_W)
  ) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (acc_valid),
    .upd_line (acc_line),
    .upd_id   (acc_id),
    .upd_idx  (idx_q),
    .look_kind(look_kind),
    .look_pos (look_pos),
    .look_id  (look_id),
    .look_idx (look_idx)
  );

  rsd_hist #(
    .DEPTH(DEPTH),
    .CNT_W(CNT_W)
  ) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_en  (acc_valid),
    .inc_bin (look_pos),
    .qry_en  (qry_valid),
    .qry_size(qry_size),
    .qry_done(qry_done),
    .qry_sum (qry_misses)
  );

  // Next-state for the result registers.
  logic             vld_d, inf_d;
  logic [IDX_W-1:0] reuse_d;
  logic [POS_W-1:0] stack_d;
  logic [ID_W-1:0]  cur_d, prev_d;

  always_comb begin
    idx_d   = idx_q + IDX_W'(1);
    vld_d   = acc_valid;
    stack_d = look_pos;
    cur_d   = acc_id;
    if (look_kind == rsd_pkg::LOOK_FOUND) begin
      inf_d   = 1'b0;
      reuse_d = idx_q - look_idx - IDX_W'(1);
      prev_d  = look_id;
    end else begin
      inf_d   = 1'b1;
      reuse_d = {IDX_W{1'b1}};
      prev_d  = '0;
    end
  end

  logic             vld_q, inf_q;
  logic [IDX_W-1:0] reuse_q;
  logic [POS_W-1:0] stack_q;
  logic [ID_W-1:0]  cur_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      vld_q   <= 1'b0;
      inf_q   <= 1'b0;
      reuse_q <= '0;
      stack_q <= '0;
      cur_q   <= '0;
      prev_q  <= '0;
    end else begin
      vld_q <= vld_d;
      if (acc_valid) begin
        idx_q   <= idx_d;
        inf_q   <= inf_d;
        reuse_q <= reuse_d;
        stack_q <= stack_d;
        cur_q   <= cur_d;
        prev_q  <= prev_d;
      end
    end
  end

  assign res_valid   = vld_q;
  assign res_reuse   = reuse_q;
  assign res_stack   = stack_q;
  assign res_inf     = inf_q;
  assign res_cur_id  = cur_q;
  assign res_prev_id = prev_q;

  // SUM_W names the width of qry_misses. This ties it to the port.
  initial begin
    if ($bits(qry_misses) != SUM_W) $error("rsd_profiler: width mismatch");
  end
endmodule

// File: rtl/rsd_profiler_chk.sv
module rsd_profiler_chk #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned ID_W   = 6,
  parameter int unsigned IDX_W  = 12,
  parameter int unsigned CNT_W  = 10,
  localparam int unsigned POS_W = $clog2(DEPTH + 1)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     acc_valid,
  input logic [ADDR_W-1:0]        acc_line,
  input logic [ID_W-1:0]          acc_id,
  input logic                     qry_valid,
  input logic                     res_valid,
  input logic [IDX_W-1:0]         res_reuse,
  input logic [POS_W-1:0]         res_stack,
  input logic                     res_inf,
  input logic [ID_W-1:0]          res_cur_id,
  input logic [ID_W-1:0]          res_prev_id,
  input logic                     qry_done
);
  localparam logic [POS_W-1:0] INF_CODE = POS_W'(DEPTH);

  p_valid_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(acc_valid));

  p_done_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    qry_done == $past(qry_valid));

  p_inf_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_inf) |->
      (res_stack == INF_CODE && res_reuse == {IDX_W{1'b1}} && res_prev_id == '0));

  p_found_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_inf) |-> (res_stack < INF_CODE));

  p_repeat_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(acc_valid, 2) && ($past(acc_line, 1) == $past(acc_line, 2)))
      |-> (res_stack == '0 && !res_inf && res_reuse == '0));

  p_cur_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_cur_id == $past(acc_id)));
endmodule

bind rsd_profiler rsd_profiler_chk #(
  .DEPTH (DEPTH),
  .ADDR_W(ADDR_W),
  .ID_W  (ID_W),
  .IDX_W (IDX_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_line   (acc_line),
  .acc_id     (acc_id),
  .qry_valid  (qry_valid),
  .res_valid  (res_valid),
  .res_reuse  (res_reuse),
  .res_stack  (res_stack),
  .res_inf    (res_inf),
  .res_cur_id (res_cur_id),
  .res_prev_id(res_prev_id),
  .qry_done   (qry_done)
);

// File: tb/tb_rsd_profiler.sv
module tb_rsd_profiler;
  localparam int CLK_P  = 10;
  localparam int DEPTH  = 8;
  localparam int ADDR_W = 12;
  localparam int ID_W   = 6;
  localparam int IDX_W  = 12;
  localparam int CNT_W  = 10;
  localparam int POS_W  = $clog2(DEPTH + 1);
  localparam int SUM_W  = CNT_W + POS_W;
  localparam int IDX_MASK = (1 << IDX_W) - 1;
  localparam int BIN_MAX  = (1 << CNT_W) - 1;

  logic              clk;
  logic              rst_n;
  logic              acc_valid;
  logic [ADDR_W-1:0] acc_line;
  logic [ID_W-1:0]   acc_id;
  logic              qry_valid;
  logic [POS_W-1:0]  qry_size;
  logic              res_valid;
  logic [IDX_W-1:0]  res_reuse;
  logic [POS_W-1:0]  res_stack;
  logic              res_inf;
  logic [ID_W-1:0]   res_cur_id;
  logic [ID_W-1:0]   res_prev_id;
  logic              qry_done;
  logic [SUM_W-1:0]  qry_misses;

  rsd_profiler #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .ID_W(ID_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_line(acc_line),
    .acc_id(acc_id), .qry_valid(qry_valid), .qry_size(qry_size),
    .res_valid(res_valid), .res_reuse(res_reuse), .res_stack(res_stack),
    .res_inf(res_inf), .res_cur_id(res_cur_id), .res_prev_id(res_prev_id),
    .qry_done(qry_done), .qry_misses(qry_misses)
  );

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // Reference model: MRU-first queues and a plain histogram.
  int m_line[$];
  int m_id[$];
  int m_idx[$];
  int m_bins[DEPTH + 1];
  int m_cnt = 0;

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, sample at the next falling edge.
  task automatic step(bit av, int line, int id, bit qv, int size, string note);
    int pos;
    int e_stack, e_reuse, e_prev, e_sum, sz;
    bit e_inf;
    acc_valid = av;
    acc_line  = line[ADDR_W-1:0];
    acc_id    = id[ID_W-1:0];
    qry_valid = qv;
    qry_size  = size[POS_W-1:0];

    pos = -1;
    for (int k = 0; k < m_line.size(); k++)
      if (pos < 0 && m_line[k] == line) pos = k;
    if (pos >= 0) begin
      e_stack = pos;
      e_inf   = 0;
      e_reuse = (m_cnt - m_idx[pos] - 1) & IDX_MASK;
      e_prev  = m_id[pos];
    end else begin
      e_stack = DEPTH;
      e_inf   = 1;
      e_reuse = IDX_MASK;
      e_prev  = 0;
    end
    // R9: the query sees the histogram before this cycle's access.
    sz = (size > DEPTH) ? DEPTH : size;
    e_sum = 0;
    for (int b = sz; b <= DEPTH; b++) e_sum += m_bins[b];

    @(posedge clk);
    @(negedge clk);

    check($sformatf("%s R2 res_valid", note), res_valid, av);
    if (av) begin
      check($sformatf("%s R3 res_stack", note), res_stack, e_stack);
      check($sformatf("%s R4 res_inf", note), res_inf, e_inf);
      check($sformatf("%s R5 res_reuse", note), res_reuse, e_reuse);
      check($sformatf("%s R6 res_cur_id", note), res_cur_id, id & ((1 << ID_W) - 1));
      check($sformatf("%s R6 res_prev_id", note), res_prev_id, e_prev);
    end
    check($sformatf("%s R9 qry_done", note), qry_done, qv);
    if (qv) check($sformatf("%s R8 qry_misses size=%0d", note, size), qry_misses, e_sum);

    if (av) begin
      if (m_bins[e_stack] < BIN_MAX) m_bins[e_stack]++;
      if (pos >= 0) begin
        m_line.delete(pos);
        m_id.delete(pos);
        m_idx.delete(pos);
      end
      m_line.push_front(line);
      m_id.push_front(id & ((1 << ID_W) - 1));
      m_idx.push_front(m_cnt);
      if (m_line.size() > DEPTH) begin
        void'(m_line.pop_back());
        void'(m_id.pop_back());
        void'(m_idx.pop_back());
      end
      m_cnt++;
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned lf;
    for (int b = 0; b <= DEPTH; b++) m_bins[b] = 0;
    rst_n = 1'b0;
    acc_valid = 1'b0; acc_line = '0; acc_id = '0;
    qry_valid = 1'b0; qry_size = '0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset.
    check("R1 res_valid in reset", res_valid, 0);
    check("R1 qry_done in reset", qry_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 res_valid after reset", res_valid, 0);
    // R1: empty histogram.
    step(0, 0, 0, 1, 0, "R1");
    // R4: first touch of a fresh line.
    step(1, 'h010, 1, 0, 0, "R4 first");

    // R3 R5 R6: directed pattern A B A A C B B A.
    step(1, 'h020, 2, 0, 0, "R3");
    step(1, 'h010, 3, 0, 0, "R3");
    step(1, 'h010, 4, 0, 0, "R3 repeat");
    step(1, 'h030, 5, 0, 0, "R3");
    step(0, 0, 0, 0, 0, "idle");
    step(1, 'h020, 6, 0, 0, "R5");
    step(1, 'h020, 7, 0, 0, "R5");
    step(1, 'h010, 8, 1, 0, "R6");

    // R7: DEPTH-1 distinct lines in between keeps the line.
    step(1, 'h100, 9, 0, 0, "R7");
    for (int k = 0; k < DEPTH - 1; k++) step(1, 'h200 + k, 10 + k, 0, 0, "R7 fill");
    step(1, 'h100, 20, 0, 0, "R7 edge kept");
    // R7: DEPTH distinct lines in between pushes it out.
    step(1, 'h300, 21, 0, 0, "R7");
    for (int k = 0; k < DEPTH; k++) step(1, 'h400 + k, 22 + k, 0, 0, "R7 fill");
    step(1, 'h300, 40, 0, 0, "R7 edge lost");

    // R8 R9: mixed traffic, queries often in the same cycle as an access.
    lf = 32'hACE1;
    for (int k = 0; k < 400; k++) begin
      lf = lf[0] ? ((lf >> 1) ^ 32'h0000B400) : (lf >> 1);
      step((lf & 7) != 0, 'h500 + int'(lf % 12), int'((lf >> 4) & 63),
           (k % 3) == 0, int'((lf >> 8) % (DEPTH + 2)), "R9 mix");
    end

    // R10: sizes above DEPTH collapse to the infinite bin.
    for (int s = 0; s < (1 << POS_W); s++) step(0, 0, 0, 1, s, "R10 sweep");

    // R11: one bin saturates.
    for (int k = 0; k < BIN_MAX + 80; k++) step(1, 'h777, k & 63, 0, 0, "R11 fill");
    step(0, 0, 0, 1, 0, "R11 total");
    step(0, 0, 0, 1, 1, "R11 nonzero bins");

    finished = 1;
    summary();
    $finish;
  end
endmodule